// File: doc/BRIEF.md
# Vector arithmetic exception recorder

This block collects arithmetic exception reports from the function units of a vector engine and folds them into a 32-bit summary register. Each report carries four things: a condition type, a 4-bit destination vector register number, the enable bit taken from bit 13 of the instruction's control word, and the instruction class. The block first decides whether the report counts. It then sets one bit for the condition type and one bit for the destination register.

Several instructions may be in flight at once and may be chained together. Because of this, the register accumulates the union of every condition type and every destination register reported since software last cleared it. That union can include instructions issued after the end of a chain.

A pending output tells the control logic that a disabled fault has to be raised. Software reads the summary through `summary_o` and empties it with a one-cycle clear pulse. When a new report arrives in the same cycle as the clear, the new report is kept.

Top module: `vec_exc_recorder`

## Requirements
- R1: After reset, `summary_o` is zero and `pending_o` is low.
- R2: An accepted report takes effect one clock after it is presented. It sets `summary_o[16+dest]` and the flag bit of its condition code: code 0 float underflow, 1 float divide-by-zero, 2 float reserved operand, 3 float overflow, 4 integer overflow. Bits 15:5 stay zero.
- R3: Reports OR into the register. Reports from several units in the same cycle, and from successive cycles, all stay set until a clear, so multiple condition flags and multiple destination bits can be set together.
- R4: For integer class (class 0), an integer-overflow report is dropped when its enable bit is 0 and recorded when it is 1.
- R5: For floating class (class 1), a float-underflow report is dropped when its enable bit is 0 and recorded when it is 1.
- R6: The enable bit has no effect on any other report. This covers load/gather class (class 2), where bit 13 means something unrelated, logical class (class 3), and every other condition code in classes 0 and 1.
- R7: A report whose condition code is 5, 6 or 7 is dropped entirely: no flag bit and no destination bit.
- R8: `pending_o` rises one clock after the first recorded report and stays high through idle cycles until a clear.
- R9: A clear with no accepted report in the same cycle makes `summary_o` zero and `pending_o` low on the next clock.
- R10: A clear in the same cycle as accepted reports leaves exactly those reports' bits in `summary_o` and keeps `pending_o` high.
- R11: In a cycle with no valid report and no clear, `summary_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rpt_valid_i | input | 2 | One report valid bit per function unit |
| rpt_cond_i | input | 6 | Condition code for each unit, 3 bits per unit, unit 0 in bits 2:0 |
| rpt_dest_i | input | 8 | Destination register number for each unit, 4 bits per unit |
| rpt_en_bit_i | input | 2 | Bit 13 of the control word for each unit |
| rpt_class_i | input | 4 | Instruction class for each unit, 2 bits per unit: 0 integer, 1 floating, 2 load/gather, 3 logical |
| clr_i | input | 1 | Software clear pulse |
| summary_o | output | 32 | Destination mask in bits 31:16, condition flags in bits 4:0 |
| pending_o | output | 1 | Disabled-fault request |

## Verification
The assertions check four things on every cycle. No summary bit falls without a clear. A plain clear empties the register. A clear that collides with a report keeps exactly the incoming bits. The pending flag always agrees with the summary contents. They also watch the enable gating on unit 0, dropped illegal codes, and idle cycles at the ports.

Other behaviours can only be shown by the bench's scenarios with known expected words. These are the exact bit placement of each condition code and destination, the merging of two units in one cycle, and the different meaning of bit 13 across the four classes.

// File: rtl/vexc_pkg.sv
package vexc_pkg;
  localparam int COND_W   = 3;
  localparam int NUM_COND = 5;

  typedef enum logic [COND_W-1:0] {
    COND_FUNF = 3'd0,
    COND_FDZ  = 3'd1,
    COND_FROP = 3'd2,
    COND_FOVF = 3'd3,
    COND_IOVF = 3'd4
  } vexc_cond_e;

  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT   = 2'd0,
    CLS_FLT   = 2'd1,
    CLS_MEM   = 2'd2,
    CLS_LOGIC = 2'd3
  } vexc_cls_e;
endpackage

// File: rtl/vexc_filter.sv
module vexc_filter
  import vexc_pkg::*;
#(
  parameter int NUM_VREGS = 16,
  localparam int DEST_W = $clog2(NUM_VREGS)
) (
  input  logic                 valid_i,
  input  logic [COND_W-1:0]    cond_i,
  input  logic [DEST_W-1:0]    dest_i,
  input  logic                 en_bit_i,
  input  logic [CLS_W-1:0]     class_i,
  output logic                 hit_o,
  output logic [NUM_VREGS-1:0] dest_mask_o,
  output logic [NUM_COND-1:0]  cond_flags_o
);
  logic code_ok;
  logic gated;

  always_comb begin
    code_ok = cond_i < COND_W'(NUM_COND);
    // bit 13 enables only these two pairs; for load/gather it is a hint
    gated   = ((class_i == CLS_INT) && (cond_i == COND_IOVF)) ||
              ((class_i == CLS_FLT) && (cond_i == COND_FUNF));
    hit_o   = valid_i && code_ok && (!gated || en_bit_i);
    dest_mask_o = hit_o ? (NUM_VREGS'(1) << dest_i) : '0;
    for (int c = 0; c < NUM_COND; c++) begin
      cond_flags_o[c] = hit_o && (cond_i == COND_W'(c));
    end
  end
endmodule

// File: rtl/vexc_summary_reg.sv
module vexc_summary_reg #(
  parameter int SUM_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [SUM_W-1:0] set_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             pending_o
);
  logic [SUM_W-1:0] sum_q;
  logic             pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      pend_q <= 1'b0;
    end else if (clr_i) begin
      sum_q  <= set_i;   // same-cycle report survives the clear
      pend_q <= hit_i;
    end else begin
      sum_q  <= sum_q | set_i;
      pend_q <= pend_q | hit_i;
    end
  end

  assign sum_o     = sum_q;
  assign pending_o = pend_q;

  assert_sticky_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((sum_q & $past(sum_q)) == $past(sum_q)));

  assert_clear_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> (sum_q == '0 && !pend_q));

  assert_clear_keeps_new_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit_i) |=> (sum_q == $past(set_i) && pend_q));

  assert_pending_tracks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q == (sum_q != '0));
endmodule

// File: rtl/vec_exc_recorder.sv
module vec_exc_recorder
  import vexc_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  parameter int NUM_VREGS = 16,
  localparam int DEST_W = $clog2(NUM_VREGS),
  localparam int SUM_W  = 2 * NUM_VREGS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_UNITS-1:0]        rpt_valid_i,
  input  logic [NUM_UNITS*COND_W-1:0] rpt_cond_i,
  input  logic [NUM_UNITS*DEST_W-1:0] rpt_dest_i,
  input  logic [NUM_UNITS-1:0]        rpt_en_bit_i,
  input  logic [NUM_UNITS*CLS_W-1:0]  rpt_class_i,
  input  logic                        clr_i,
  output logic [SUM_W-1:0]            summary_o,
  output logic                        pending_o
);
  logic [NUM_UNITS-1:0] hit;
  logic [NUM_VREGS-1:0] dest_mask [NUM_UNITS];
  logic [NUM_COND-1:0]  flags     [NUM_UNITS];
  logic [SUM_W-1:0]     set_vec;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    vexc_filter #(.NUM_VREGS(NUM_VREGS)) filt_i (
      .valid_i      (rpt_valid_i[u]),
      .cond_i       (rpt_cond_i[u*COND_W +: COND_W]),
      .dest_i       (rpt_dest_i[u*DEST_W +: DEST_W]),
      .en_bit_i     (rpt_en_bit_i[u]),
      .class_i      (rpt_class_i[u*CLS_W +: CLS_W]),
      .hit_o        (hit[u]),
      .dest_mask_o  (dest_mask[u]),
      .cond_flags_o (flags[u])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      set_vec[SUM_W-1:NUM_VREGS] = set_vec[SUM_W-1:NUM_VREGS] | dest_mask[u];
      set_vec[NUM_COND-1:0]      = set_vec[NUM_COND-1:0] | flags[u];
    end
  end

  vexc_summary_reg #(.SUM_W(SUM_W)) sum_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .hit_i     (|hit),
    .set_i     (set_vec),
    .sum_o     (summary_o),
    .pending_o (pending_o)
  );

  assert_idle_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_i == '0 && !clr_i) |=> $stable(summary_o));

  assert_int_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_i == NUM_UNITS'(1) && !clr_i && !rpt_en_bit_i[0] &&
     rpt_class_i[CLS_W-1:0] == CLS_INT && rpt_cond_i[COND_W-1:0] == COND_IOVF)
    |=> $stable(summary_o));

  assert_flt_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_i == NUM_UNITS'(1) && !clr_i && !rpt_en_bit_i[0] &&
     rpt_class_i[CLS_W-1:0] == CLS_FLT && rpt_cond_i[COND_W-1:0] == COND_FUNF)
    |=> $stable(summary_o));

  assert_bad_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_i == NUM_UNITS'(1) && !clr_i &&
     rpt_cond_i[COND_W-1:0] >= COND_W'(NUM_COND))
    |=> $stable(summary_o));

  assert_no_unused_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    summary_o[NUM_VREGS-1:NUM_COND] == '0);
endmodule

// File: tb/vec_exc_recorder_tb_top.sv
`timescale 1ns/1ps
module vec_exc_recorder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rpt_valid = '0;
  logic [5:0]  rpt_cond = '0;
  logic [7:0]  rpt_dest = '0;
  logic [1:0]  rpt_en = '0;
  logic [3:0]  rpt_class = '0;
  logic        clr = 1'b0;
  logic [31:0] summary;
  logic        pending;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vec_exc_recorder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rpt_valid_i(rpt_valid), .rpt_cond_i(rpt_cond),
    .rpt_dest_i(rpt_dest), .rpt_en_bit_i(rpt_en), .rpt_class_i(rpt_class),
    .clr_i(clr), .summary_o(summary), .pending_o(pending)
  );

  function automatic logic [31:0] bits(int cond, int dest);
    return (32'h1 << (16 + dest)) | (32'h1 << cond);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_unit(int u, int cond, int dest, bit en, int cls);
    rpt_valid[u]       = 1'b1;
    rpt_cond[u*3 +: 3] = 3'(cond);
    rpt_dest[u*4 +: 4] = 4'(dest);
    rpt_en[u]          = en;
    rpt_class[u*2 +: 2] = 2'(cls);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    rpt_valid = '0;
    clr = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 summary", summary, 32'h0);
    chk("R1 pending", {31'h0, pending}, 32'h0);
  endtask

  task automatic t_single();
    set_unit(0, 3, 3, 1'b0, 1); tick();
    chk("R2 float overflow v3", summary, bits(3, 3));
    chk("R8 pending rises", {31'h0, pending}, 32'h1);
    tick(); tick();
    chk("R11 idle stable", summary, bits(3, 3));
    chk("R8 pending held", {31'h0, pending}, 32'h1);
    do_clear();
    chk("R9 clear summary", summary, 32'h0);
    chk("R9 clear pending", {31'h0, pending}, 32'h0);
  endtask

  task automatic t_accumulate();
    set_unit(0, 4, 2, 1'b1, 0);
    set_unit(1, 1, 7, 1'b0, 1);
    tick();
    chk("R3 two units one cycle", summary, bits(4, 2) | bits(1, 7));
    set_unit(0, 2, 2, 1'b0, 1); tick();
    chk("R3 accumulate", summary, bits(4, 2) | bits(1, 7) | bits(2, 2));
    set_unit(1, 0, 15, 1'b1, 1); tick();
    chk("R2 top dest bit", summary, bits(4, 2) | bits(1, 7) | bits(2, 2) | bits(0, 15));
    do_clear();
  endtask

  task automatic t_int_gate();
    set_unit(0, 4, 5, 1'b0, 0); tick();
    chk("R4 int overflow disabled", summary, 32'h0);
    chk("R4 no pending", {31'h0, pending}, 32'h0);
    set_unit(0, 4, 5, 1'b1, 0); tick();
    chk("R4 int overflow enabled", summary, bits(4, 5));
    do_clear();
  endtask

  task automatic t_flt_gate();
    set_unit(1, 0, 6, 1'b0, 1); tick();
    chk("R5 underflow disabled", summary, 32'h0);
    set_unit(1, 0, 6, 1'b1, 1); tick();
    chk("R5 underflow enabled", summary, bits(0, 6));
    do_clear();
  endtask

  task automatic t_en_ignored();
    set_unit(0, 0, 9, 1'b0, 2); tick();
    chk("R6 load class bit13 clear", summary, bits(0, 9));
    set_unit(0, 4, 10, 1'b1, 2); tick();
    chk("R6 load class bit13 set", summary, bits(0, 9) | bits(4, 10));
    do_clear();
    set_unit(0, 4, 1, 1'b0, 3); tick();
    chk("R6 logical class", summary, bits(4, 1));
    set_unit(1, 1, 0, 1'b0, 1); tick();
    chk("R6 divide by zero ungated", summary, bits(4, 1) | bits(1, 0));
    do_clear();
  endtask

  task automatic t_bad_code();
    for (int c = 5; c < 8; c++) begin
      set_unit(0, c, 4, 1'b1, 1); tick();
      chk("R7 illegal code dropped", summary, 32'h0);
    end
    chk("R7 no pending", {31'h0, pending}, 32'h0);
  endtask

  task automatic t_collide();
    set_unit(0, 3, 11, 1'b0, 1); tick();
    clr = 1'b1;
    set_unit(1, 4, 12, 1'b1, 0);
    tick();
    chk("R10 report survives clear", summary, bits(4, 12));
    chk("R10 pending kept", {31'h0, pending}, 32'h1);
    do_clear();
    chk("R9 final clear", summary, 32'h0);
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_accumulate();
    t_int_gate();
    t_flt_gate();
    t_en_ignored();
    t_bad_code();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule